// File: doc/BRIEF.md
# Quad Wiper Register Bank Controller

This block is the register side of a four-channel digital potentiometer. Each channel owns one volatile 6-bit wiper code, which picks one of 64 taps, and four 6-bit stored settings that stand in for nonvolatile cells. A serial front end, which is not part of this block, decodes bus traffic into single-cycle requests. Each request carries an operation code, a channel, a setting index and a data value. The block carries out the request and keeps a registered one-hot tap select for every channel.

A wiper code can change in three ways. It can be written with a value from the host, loaded in parallel from one of its stored settings, or moved up or down by one step. Loads and saves can act on one channel or on all four channels at once. Any operation that changes a stored setting takes a timed busy window, which models the slow nonvolatile write. During that window every new request is ignored. A write-protect input refuses such operations outright. After a synchronous reset, every wiper code is recalled from the channel's setting 0. The stored settings themselves survive reset.

Top module: `quad_wiper_bank`

## Requirements
- R1: The clock edge that samples `rst` high loads each wiper code from setting 0 of its channel, and clears `busy` and `rd_valid`. Stored settings keep their contents across reset. At power-up, setting r of channel p holds (7*(4*p+r) + DR_SEED) mod 64.
- R2: `tap_sel[p*64+k]` is 1 exactly when the wiper code of channel p equals k: code 0 selects bit 0 (low end) and code 63 selects bit 63 (high end). Exactly one bit per channel is set, and it updates on the same edge as `wiper_code`.
- R3: Op 1 (write wiper) sets the code of `req_pot` to `req_data` at the next edge. Op 0 (read wiper) gives `rd_valid`=1 and `rd_data` equal to that channel's code one cycle later.
- R4: Op 2 (read setting) gives `rd_valid`=1 and `rd_data` equal to setting `req_reg` of `req_pot` one cycle later.
- R5: Op 4 (load) copies setting `req_reg` of `req_pot` into that channel's wiper code at the next edge. The other channels do not change.
- R6: Op 6 (load all) copies setting `req_reg` of each channel into its own wiper code, on the same edge for all four channels.
- R7: Op 8 raises and op 9 lowers the code of `req_pot` by one. A raise at 63 and a lower at 0 leave the code unchanged.
- R8: Op 3 (write setting from `req_data`), op 5 (save the wiper of `req_pot`) and op 7 (save all four wipers) capture their data at the request edge. They hold `busy` high for NV_CYCLES cycles, and the target setting(s) `req_reg` change on the edge where `busy` falls.
- R9: While `busy` is high, every request is ignored: no code changes, no read response, and no new write.
- R10: With `wp_n` low, ops 3, 5 and 7 leave `busy` low and the settings unchanged. Volatile ops still act.
- R11: Op codes 10 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; recalls setting 0 |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 4 | Operation code (see requirements) |
| req_pot | input | 2 | Channel select |
| req_reg | input | 2 | Stored-setting select |
| req_data | input | 6 | Data for write operations |
| wp_n | input | 1 | Low blocks all stored-setting writes |
| busy | output | 1 | Nonvolatile write window in progress |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 6 | Read response value |
| wiper_code | output | 24 | Four packed wiper codes, channel 0 in the low bits |
| tap_sel | output | 256 | Four packed 64-bit one-hot tap selects |

## Verification
Wiper codes, tap selects and read responses are all due one edge after the request edge. A stored-setting write becomes visible on the edge where `busy` falls, NV_CYCLES edges after the request. `busy` itself rises on the edge that accepts the request. The bench updates a behavioural model just after each rising edge and compares every output at the following falling edge, so each result is checked in the exact cycle it is due and not only at some later point. Requests placed inside the busy window, and nonvolatile requests made under write protect, are then read back through the normal read operations.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'd0,
    OP_WR_WIPER = 4'd1,
    OP_RD_DATA  = 4'd2,
    OP_WR_DATA  = 4'd3,
    OP_LOAD     = 4'd4,
    OP_SAVE     = 4'd5,
    OP_LOAD_ALL = 4'd6,
    OP_SAVE_ALL = 4'd7,
    OP_STEP_UP  = 4'd8,
    OP_STEP_DN  = 4'd9
  } op_e;
endpackage

// File: rtl/qwb_onehot_dec.sv
module qwb_onehot_dec #(
  parameter int WB = 6
) (
  input  logic [WB-1:0]      code,
  output logic [(1<<WB)-1:0] onehot
);
  localparam int TAPS = 1 << WB;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign onehot[k] = (code == WB'(k));
  end
endmodule

// File: rtl/qwb_nv_timer.sv
module qwb_nv_timer #(
  parameter int CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end
  end

  // R8
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == '0) |=> !busy);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/qwb_wiper_slice.sv
module qwb_wiper_slice #(
  parameter int WB = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WB-1:0]      recall_val,
  input  logic               load_en,
  input  logic [WB-1:0]      load_val,
  input  logic               step_en,
  input  logic               step_up,
  output logic [WB-1:0]      code,
  output logic [(1<<WB)-1:0] taps
);
  localparam int TAPS = 1 << WB;
  localparam logic [WB-1:0] MAXC = WB'(TAPS - 1);

  logic [WB-1:0]   nxt;
  logic [TAPS-1:0] nxt_taps;

  always_comb begin
    nxt = code;
    if (rst)                             nxt = recall_val;
    else if (load_en)                    nxt = load_val;
    else if (step_en && step_up  && code != MAXC) nxt = code + 1'b1;
    else if (step_en && !step_up && code != '0)   nxt = code - 1'b1;
  end

  qwb_onehot_dec #(.WB(WB)) u_dec (.code(nxt), .onehot(nxt_taps));

  always_ff @(posedge clk) begin
    code <= nxt;
    taps <= nxt_taps;
  end

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(taps) == 1) && taps[code]);

  // R1
  recall_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code == $past(recall_val)));

  // R7
  step_hi_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up && !load_en && code == MAXC) |=> (code == MAXC));

  // R7
  step_lo_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_up && !load_en && code == '0) |=> (code == '0));

  // R7
  step_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up && !load_en && code != MAXC) |=> (code == $past(code) + 1'b1));
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank #(
  parameter int NPOT      = 4,
  parameter int NREG      = 4,
  parameter int WB        = 6,
  parameter int NV_CYCLES = 1250000,
  parameter int DR_SEED   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [3:0]               req_op,
  input  logic [$clog2(NPOT)-1:0]  req_pot,
  input  logic [$clog2(NREG)-1:0]  req_reg,
  input  logic [WB-1:0]            req_data,
  input  logic                     wp_n,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [WB-1:0]            rd_data,
  output logic [NPOT*WB-1:0]       wiper_code,
  output logic [NPOT*(1<<WB)-1:0]  tap_sel
);
  import qwb_pkg::*;

  localparam int TAPS  = 1 << WB;
  localparam int PSEL  = $clog2(NPOT);
  localparam int RSEL  = $clog2(NREG);
  localparam int DEPTH = NPOT * NREG;

  logic [WB-1:0] dr_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) dr_mem[i] = WB'((7 * i + DR_SEED) % TAPS);
  end

  logic [WB-1:0] wcr      [NPOT];
  logic [NPOT-1:0] load_en, step_en, nv_mask;
  logic [WB-1:0] load_val [NPOT];
  logic [WB-1:0] nv_data  [NPOT];
  logic          step_up, rd_set, nv_start, commit;
  logic [WB-1:0] rd_val;
  logic          accept;

  logic [NPOT-1:0] pend_mask;
  logic [RSEL-1:0] pend_reg;
  logic [WB-1:0]   pend_data [NPOT];

  assign accept = req_valid && !busy && !rst;

  always_comb begin
    load_en  = '0;
    step_en  = '0;
    nv_mask  = '0;
    step_up  = 1'b0;
    rd_set   = 1'b0;
    rd_val   = '0;
    nv_start = 1'b0;
    for (int p = 0; p < NPOT; p++) begin
      load_val[p] = '0;
      nv_data[p]  = '0;
    end
    if (accept) begin
      case (req_op)
        OP_RD_WIPER: begin
          rd_set = 1'b1;
          rd_val = wcr[req_pot];
        end
        OP_WR_WIPER: begin
          load_en[req_pot]  = 1'b1;
          load_val[req_pot] = req_data;
        end
        OP_RD_DATA: begin
          rd_set = 1'b1;
          rd_val = dr_mem[{req_pot, req_reg}];
        end
        OP_WR_DATA: if (wp_n) begin
          nv_start         = 1'b1;
          nv_mask[req_pot] = 1'b1;
          nv_data[req_pot] = req_data;
        end
        OP_LOAD: begin
          load_en[req_pot]  = 1'b1;
          load_val[req_pot] = dr_mem[{req_pot, req_reg}];
        end
        OP_SAVE: if (wp_n) begin
          nv_start         = 1'b1;
          nv_mask[req_pot] = 1'b1;
          nv_data[req_pot] = wcr[req_pot];
        end
        OP_LOAD_ALL: begin
          for (int p = 0; p < NPOT; p++) begin
            load_en[p]  = 1'b1;
            load_val[p] = dr_mem[{PSEL'(p), req_reg}];
          end
        end
        OP_SAVE_ALL: if (wp_n) begin
          nv_start = 1'b1;
          for (int p = 0; p < NPOT; p++) begin
            nv_mask[p] = 1'b1;
            nv_data[p] = wcr[p];
          end
        end
        OP_STEP_UP, OP_STEP_DN: begin
          step_en[req_pot] = 1'b1;
          step_up          = (req_op == OP_STEP_UP);
        end
        default: ;
      endcase
    end
  end

  qwb_nv_timer #(.CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(nv_start), .busy(busy), .done(commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mask <= '0;
      pend_reg  <= '0;
    end else if (nv_start) begin
      pend_mask <= nv_mask;
      pend_reg  <= req_reg;
    end
    if (nv_start) begin
      for (int p = 0; p < NPOT; p++) pend_data[p] <= nv_data[p];
    end
  end

  always_ff @(posedge clk) begin
    if (commit && !rst) begin
      for (int p = 0; p < NPOT; p++) begin
        if (pend_mask[p]) dr_mem[{PSEL'(p), pend_reg}] <= pend_data[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_set;
      if (rd_set) rd_data <= rd_val;
    end
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    qwb_wiper_slice #(.WB(WB)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .recall_val(dr_mem[{PSEL'(p), RSEL'(0)}]),
      .load_en   (load_en[p]),
      .load_val  (load_val[p]),
      .step_en   (step_en[p]),
      .step_up   (step_up),
      .code      (wcr[p]),
      .taps      (tap_sel[p*TAPS +: TAPS])
    );
    assign wiper_code[p*WB +: WB] = wcr[p];
  end

  logic nv_req;
  assign nv_req = (req_op == OP_WR_DATA) || (req_op == OP_SAVE) || (req_op == OP_SAVE_ALL);

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !wp_n && nv_req) |=> !busy);

  // R8
  nv_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && wp_n && nv_req) |=> busy);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> !rd_valid);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(wiper_code));
endmodule

// File: tb/sim_quad_wiper_bank.sv
`timescale 1ns/1ps
module sim_quad_wiper_bank;
  localparam int NVC  = 12;
  localparam int SEED = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_pot = '0;
  logic [1:0]  req_reg = '0;
  logic [5:0]  req_data = '0;
  logic        wp_n = 1'b1;
  logic        busy, rd_valid;
  logic [5:0]  rd_data;
  logic [23:0] wiper_code;
  logic [255:0] tap_sel;

  quad_wiper_bank #(.NV_CYCLES(NVC), .DR_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_pot(req_pot), .req_reg(req_reg), .req_data(req_data), .wp_n(wp_n),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .wiper_code(wiper_code), .tap_sel(tap_sel)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur = "R1";
  bit started = 0;

  int m_wcr [4];
  int m_dr  [16];
  int m_busy, m_cnt, m_rdv, m_rdd, m_preg;
  int m_pmask [4];
  int m_pdat  [4];

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (!started) return;
    for (int p = 0; p < 4; p++) begin
      logic [63:0] et;
      et = 64'd1 << m_wcr[p];
      chk(cur, $sformatf("wiper_code[%0d]", p), longint'(wiper_code[p*6 +: 6]), longint'(m_wcr[p]));
      checks++;
      if (tap_sel[p*64 +: 64] != et) begin
        fails++;
        $display("FAIL R2 tap_sel[%0d]: actual %h expected %h", p, tap_sel[p*64 +: 64], et);
      end
    end
    chk(cur, "busy", longint'(busy), longint'(m_busy));
    chk(cur, "rd_valid", longint'(rd_valid), longint'(m_rdv));
    if (m_rdv != 0) chk(cur, "rd_data", longint'(rd_data), longint'(m_rdd));
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[p*4];
      m_busy = 0; m_rdv = 0;
      started = 1;
      return;
    end
    m_rdv = 0;
    if (m_busy != 0) begin
      if (m_cnt == 0) begin
        for (int p = 0; p < 4; p++) if (m_pmask[p] != 0) m_dr[p*4 + m_preg] = m_pdat[p];
        m_busy = 0;
      end else m_cnt--;
    end else if (req_valid) begin
      int p, r, d;
      p = int'(req_pot); r = int'(req_reg); d = int'(req_data);
      case (req_op)
        4'd0: begin m_rdv = 1; m_rdd = m_wcr[p]; end
        4'd1: m_wcr[p] = d;
        4'd2: begin m_rdv = 1; m_rdd = m_dr[p*4 + r]; end
        4'd4: m_wcr[p] = m_dr[p*4 + r];
        4'd6: for (int q = 0; q < 4; q++) m_wcr[q] = m_dr[q*4 + r];
        4'd8: if (m_wcr[p] < 63) m_wcr[p]++;
        4'd9: if (m_wcr[p] > 0) m_wcr[p]--;
        4'd3, 4'd5, 4'd7: if (wp_n) begin
          m_busy = 1; m_cnt = NVC - 1; m_preg = r;
          for (int q = 0; q < 4; q++) m_pmask[q] = 0;
          if (req_op == 4'd7) begin
            for (int q = 0; q < 4; q++) begin m_pmask[q] = 1; m_pdat[q] = m_wcr[q]; end
          end else begin
            m_pmask[p] = 1;
            m_pdat[p] = (req_op == 4'd3) ? d : m_wcr[p];
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic cyc(logic v, logic [3:0] op, int pot, int rs, int data);
    @(negedge clk);
    compare_all();
    req_valid = v; req_op = op;
    req_pot = 2'(pot); req_reg = 2'(rs); req_data = 6'(data);
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 0, 0, 0);
  endtask

  task automatic req(logic [3:0] op, int pot, int rs, int data);
    cyc(1'b1, op, pot, rs, data);
  endtask

  task automatic do_reset(int n);
    rst = 1'b1;
    idle(n);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_dr[i] = (7 * i + SEED) % 64;
    m_busy = 0; m_cnt = 0; m_rdv = 0; m_rdd = 0; m_preg = 0;
    for (int q = 0; q < 4; q++) begin m_wcr[q] = 0; m_pmask[q] = 0; m_pdat[q] = 0; end

    cur = "R1"; do_reset(3); idle(2);

    cur = "R3";
    for (int p = 0; p < 4; p++) req(4'd0, p, 0, 0);
    req(4'd1, 1, 0, 6'h2A); req(4'd0, 1, 0, 0); idle(1);

    cur = "R4";
    for (int i = 0; i < 16; i += 3) req(4'd2, i / 4, i % 4, 0);
    idle(1);

    cur = "R5"; req(4'd4, 2, 3, 0); req(4'd0, 2, 0, 0); idle(1);

    cur = "R7";
    req(4'd8, 1, 0, 0); req(4'd8, 1, 0, 0); req(4'd9, 1, 0, 0);
    req(4'd1, 0, 0, 62);
    for (int i = 0; i < 3; i++) req(4'd8, 0, 0, 0);
    req(4'd1, 3, 0, 1);
    for (int i = 0; i < 3; i++) req(4'd9, 3, 0, 0);
    idle(1);

    cur = "R6"; req(4'd6, 0, 2, 0); idle(1);

    cur = "R8"; req(4'd3, 0, 1, 6'h15);
    cur = "R9";
    req(4'd1, 2, 0, 6'h11); req(4'd0, 2, 0, 0); req(4'd8, 3, 0, 0); req(4'd3, 1, 1, 6'h3F);
    idle(NVC);
    cur = "R8"; req(4'd2, 0, 1, 0); req(4'd2, 1, 1, 0); idle(1);

    req(4'd1, 3, 0, 6'h33); req(4'd5, 3, 0, 0); idle(NVC + 1);
    cur = "R1"; do_reset(2); idle(1); req(4'd2, 3, 0, 0); idle(1);

    cur = "R8"; req(4'd1, 2, 0, 6'h07); req(4'd7, 0, 3, 0); idle(NVC + 1);
    req(4'd6, 0, 3, 0); idle(1);

    cur = "R10"; wp_n = 1'b0;
    req(4'd3, 2, 2, 6'h01); req(4'd7, 0, 1, 0); req(4'd5, 1, 0, 0); idle(2);
    for (int p = 0; p < 4; p++) begin req(4'd2, p, 1, 0); req(4'd2, p, 2, 0); end
    req(4'd1, 0, 0, 6'h3C); req(4'd9, 0, 0, 0); idle(1);
    wp_n = 1'b1;

    cur = "R11";
    for (int op = 10; op < 16; op++) req(4'(op), op % 4, 1, 6'h2B);
    idle(2);

    cur = "R7"; req(4'd1, 2, 0, 0); req(4'd9, 2, 0, 0); req(4'd1, 2, 0, 63); req(4'd8, 2, 0, 0); idle(2);

    @(negedge clk);
    compare_all();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule